// File: doc/BRIEF.md
# Switch-Driven Register File Console

This block is a small hand-operated datapath. A user drives a 32-entry, 32-bit register file and a compact ALU using sixteen switches and four push buttons, and reads the results on sixteen LEDs. One 15-bit address register holds all three register addresses: the first source, the second source and the destination. The user loads that register from the switches with the load button.

A press of the write button stores one word into the destination register. Switch 15 selects where that word comes from. When it is low, the word is the ALU result for the two source registers, and the operation code comes from the low four switches. When it is high, the word is the low fifteen switches, sign-extended to 32 bits.

The LEDs show the first source register one half at a time. The half button selects which half. Register 0 always reads as zero.

The write button passes through a two-flop synchronizer and a rising-edge detector. Each press therefore yields one write, however long the button is held. The load button is synchronized as well, and it enables the address register at a steady level while it is held. The register file reads synchronously. If a read address matches the register being written in the same cycle, the read returns the new value.

Top module: `regcon_top`

## Requirements
- R1: While `rst_btn` is high at a clock edge, the address register and every register file entry are cleared to zero, so all LEDs read zero after reset.
- R2: Each cycle in which the synchronized load button is high, the address register captures `sw[14:0]`. Bits [4:0] select the first source, bits [9:5] select the second source and bits [14:10] select the destination.
- R3: A press of `wr_btn` produces exactly one write, a single-cycle strobe, however many cycles the button is held.
- R4: With `sw[15]`=1, the written word is `sw[14:0]` sign-extended from bit 14 to 32 bits.
- R5: With `sw[15]`=0, the written word is the ALU result on source 1 (A) and source 2 (B), with opcode `sw[3:0]`: 0000 A AND B, 0001 A OR B, 0010 A+B, 0110 A-B, 0111 signed A<B giving 1 or 0, 1101 A XOR B.
- R6: Register 0 always reads zero. Writes addressed to it are ignored.
- R7: `led` shows bits [15:0] of the first source register while `half_btn` is low and bits [31:16] while it is high, with no added delay.
- R8: The register file reads synchronously in write-first order: a read port whose address equals the write address in a writing cycle returns the newly written word.
- R9: Any opcode other than the six in R5 yields a result of zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_btn | input | 1 | Synchronous active-high reset button |
| ld_btn | input | 1 | Load address register from switches |
| wr_btn | input | 1 | Write one word to the destination register |
| half_btn | input | 1 | Show the upper half of source 1 on the LEDs |
| sw | input | 16 | Address, constant, opcode and data-select switches |
| led | output | 16 | Selected half of source 1 |

## Verification
The bench builds the block with its default parameters: 5-bit addresses, 32-bit data and a 15-bit constant. This makes a full sweep practical. It writes a distinct constant of either sign to every register from 1 to 31, then reads back both halves of all 32 entries, including a blocked write to register 0. It applies all sixteen opcodes in both operand orders, which covers the zero result for unused codes and both outcomes of the signed compare. It then holds the write button for many cycles on a read-modify-write of a single register, so a repeated strobe would show up as a second accumulation.

// File: rtl/regcon_pkg.sv
package regcon_pkg;
  typedef enum logic [3:0] {
    OP_AND = 4'b0000,
    OP_OR  = 4'b0001,
    OP_ADD = 4'b0010,
    OP_SUB = 4'b0110,
    OP_SLT = 4'b0111,
    OP_XOR = 4'b1101
  } alu_op_e;
endpackage

// File: rtl/regcon_sync_pulse.sv
module regcon_sync_pulse #(
  parameter int STAGES = 2,
  parameter bit EDGE   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_in,
  output logic level_out,
  output logic pulse_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], btn_in};
  end

  assign level_out = chain_q[STAGES-1];

  generate
    if (EDGE) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= level_out;
      end
      assign pulse_out = level_out & ~prev_q;

      // R3: the strobe never lasts two cycles in a row
      assert_single_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        pulse_out |=> !pulse_out);
    end else begin : g_level
      assign pulse_out = level_out;
    end
  endgenerate
endmodule

// File: rtl/regcon_regfile.sv
module regcon_regfile #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ra1,
  input  logic [ADDR_W-1:0] ra2,
  input  logic [ADDR_W-1:0] wa,
  input  logic              we,
  input  logic [DATA_W-1:0] wd,
  output logic [DATA_W-1:0] rd1,
  output logic [DATA_W-1:0] rd2
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              wr_ok;

  assign wr_ok = we && (wa != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rd1 <= '0;
      rd2 <= '0;
    end else begin
      rd1 <= mem[ra1];
      rd2 <= mem[ra2];
      if (wr_ok) begin
        mem[wa] <= wd;
        if (ra1 == wa) rd1 <= wd;
        if (ra2 == wa) rd2 <= wd;
      end
    end
  end

  // R6: entry zero reads as zero on both ports
  assert_zero_reg_p1_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ra1) == '0) |-> rd1 == '0);
  assert_zero_reg_p2_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ra2) == '0) |-> rd2 == '0);
  // R8: a matching read in a writing cycle returns the new word
  assert_write_first_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(we) && $past(wa) != '0 && $past(wa) == $past(ra1))
      |-> rd1 == $past(wd));
endmodule

// File: rtl/regcon_alu.sv
module regcon_alu
  import regcon_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [3:0]        op_sel,
  output logic [DATA_W-1:0] result
);
  always_comb begin
    case (op_sel)
      OP_AND:  result = op_a & op_b;
      OP_OR:   result = op_a | op_b;
      OP_ADD:  result = op_a + op_b;
      OP_SUB:  result = op_a - op_b;
      OP_SLT:  result = ($signed(op_a) < $signed(op_b)) ? DATA_W'(1) : '0;
      OP_XOR:  result = op_a ^ op_b;
      default: result = '0;
    endcase
  end
endmodule

// File: rtl/regcon_top.sv
module regcon_top #(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2,
  parameter int SW_W        = 3 * ADDR_W + 1,
  parameter int LED_W       = DATA_W / 2
) (
  input  logic             clk,
  input  logic             rst_btn,
  input  logic             ld_btn,
  input  logic             wr_btn,
  input  logic             half_btn,
  input  logic [SW_W-1:0]  sw,
  output logic [LED_W-1:0] led
);
  localparam int FIELD_W = 3 * ADDR_W;
  localparam int EXT_W   = DATA_W - FIELD_W;

  logic               rst;
  logic               ld_en, ld_unused;
  logic               wr_level, wr_strobe;
  logic [FIELD_W-1:0] addr_q;
  logic [ADDR_W-1:0]  src1, src2, dst;
  logic [DATA_W-1:0]  rdata1, rdata2, alu_res, imm_ext, wdata;

  assign rst = rst_btn;

  regcon_sync_pulse #(.STAGES(SYNC_STAGES), .EDGE(1'b0)) u_ld_sync (
    .clk(clk), .rst(rst), .btn_in(ld_btn),
    .level_out(ld_en), .pulse_out(ld_unused));

  regcon_sync_pulse #(.STAGES(SYNC_STAGES), .EDGE(1'b1)) u_wr_sync (
    .clk(clk), .rst(rst), .btn_in(wr_btn),
    .level_out(wr_level), .pulse_out(wr_strobe));

  always_ff @(posedge clk) begin
    if (rst)        addr_q <= '0;
    else if (ld_en) addr_q <= sw[FIELD_W-1:0];
  end

  assign src1 = addr_q[ADDR_W-1:0];
  assign src2 = addr_q[2*ADDR_W-1:ADDR_W];
  assign dst  = addr_q[3*ADDR_W-1:2*ADDR_W];

  regcon_alu #(.DATA_W(DATA_W)) u_alu (
    .op_a(rdata1), .op_b(rdata2), .op_sel(sw[3:0]), .result(alu_res));

  assign imm_ext = {{EXT_W{sw[FIELD_W-1]}}, sw[FIELD_W-1:0]};
  assign wdata   = sw[SW_W-1] ? imm_ext : alu_res;

  regcon_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rf (
    .clk(clk), .rst(rst),
    .ra1(src1), .ra2(src2), .wa(dst),
    .we(wr_strobe), .wd(wdata),
    .rd1(rdata1), .rd2(rdata2));

  assign led = half_btn ? rdata1[DATA_W-1:LED_W] : rdata1[LED_W-1:0];

  // R1: reset leaves the address register empty
  assert_reset_addr_R1: assert property (@(posedge clk)
    $past(rst) |-> addr_q == '0);
  // R2: a synchronized load captures the switch field
  assert_addr_load_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ld_en)) |-> addr_q == $past(sw[FIELD_W-1:0]));
  // R3: a strobe only appears while the synchronized button is high
  assert_strobe_level_R3: assert property (@(posedge clk) disable iff (rst)
    wr_strobe |-> wr_level);
endmodule

// File: tb/regcon_top_tb_top.sv
module regcon_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_btn = 1'b1, ld_btn = 1'b0, wr_btn = 1'b0, half_btn = 1'b0;
  logic [15:0] sw = '0;
  logic [15:0] led;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [31:0] model [32];

  always #10 clk = ~clk;

  regcon_top dut_i (.clk(clk), .rst_btn(rst_btn), .ld_btn(ld_btn),
    .wr_btn(wr_btn), .half_btn(half_btn), .sw(sw), .led(led));

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: led actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_addr(logic [4:0] d, logic [4:0] s2, logic [4:0] s1);
    sw = {1'b0, d, s2, s1}; ld_btn = 1'b1; cyc(4);
    ld_btn = 1'b0; cyc(5);
  endtask

  task automatic press_write(logic [15:0] v, int hold);
    sw = v; wr_btn = 1'b1; cyc(hold);
    wr_btn = 1'b0; cyc(5);
  endtask

  task automatic read_check(string req, logic [4:0] r, logic [31:0] exp);
    load_addr(5'd0, 5'd0, r);
    half_btn = 1'b0; #1; check(req, led, exp[15:0]);
    @(negedge clk); half_btn = 1'b1; #1; check(req, led, exp[31:16]);
    @(negedge clk); half_btn = 1'b0;
  endtask

  function automatic logic [31:0] alu_exp(logic [3:0] op, logic [31:0] a, logic [31:0] b);
    case (op)
      4'd0:  return a & b;
      4'd1:  return a | b;
      4'd2:  return a + b;
      4'd6:  return a - b;
      4'd7:  return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      4'd13: return a ^ b;
      default: return 32'd0; // R9
    endcase
  endfunction

  function automatic logic [31:0] sext(logic [14:0] v);
    return {{17{v[14]}}, v};
  endfunction

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '0;
    cyc(4); rst_btn = 1'b0; cyc(2);
    // R1: reset state
    read_check("R1", 5'd0, 32'd0);
    read_check("R1", 5'd5, 32'd0);

    // R4 sweep of constants, R2 destination field
    for (int r = 1; r < 32; r++) begin
      logic [14:0] v;
      v = 15'((r * 2731 + 97) ^ ((r & 1) << 14));
      load_addr(5'(r), 5'd0, 5'd0);
      press_write({1'b1, v}, 3);
      model[r] = sext(v);
    end
    // R6: write to entry zero has no effect
    load_addr(5'd0, 5'd0, 5'd0);
    press_write(16'hFFFF, 3);
    for (int r = 0; r < 32; r++) read_check("R4/R2/R6", 5'(r), model[r]);

    // R5/R9: every opcode, both operand orders (R2 source fields)
    for (int p = 0; p < 2; p++) begin
      for (int op = 0; op < 16; op++) begin
        logic [4:0] a, b;
        a = (p == 0) ? 5'd3 : 5'd8;
        b = (p == 0) ? 5'd8 : 5'd3;
        load_addr(5'd20, b, a);
        press_write({12'd0, 4'(op)}, 3);
        model[20] = alu_exp(4'(op), model[a], model[b]);
        read_check((op inside {0, 1, 2, 6, 7, 13}) ? "R5" : "R9", 5'd20, model[20]);
      end
    end

    // R3: long hold on x1 = x1 + x2 accumulates once
    load_addr(5'd1, 5'd2, 5'd1);
    press_write(16'h0002, 40);
    model[1] = model[1] + model[2];
    read_check("R3", 5'd1, model[1]);

    // R7 with R4: worked sequence 43 + 27
    load_addr(5'd1, 5'd0, 5'd0); press_write(16'h802B, 3);
    load_addr(5'd2, 5'd0, 5'd0); press_write(16'h801B, 3);
    load_addr(5'd3, 5'd2, 5'd1); press_write(16'h0002, 3);
    read_check("R7", 5'd3, 32'd70);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule